// File: doc/BRIEF.md
# Battery-Backed SRAM Enable Decoder

This block sits between a processor core and a byte-wide static RAM array. Each cycle it takes one logical 16-bit address and an access kind, and produces registered strobes for the memory side. These are four active-low chip enables, four active-low peripheral enables, a 15-bit byte address and an active-low write strobe. The RAM can be built from up to four 32K devices or from a single 128K device. A mode bit can also send all data-space traffic to four 16K peripheral windows.

Program fetches and data accesses each occupy their own 64K half of a 17-bit physical space. The physical address is the access-is-data bit followed by the 16 logical address bits, so fetches land in 32K blocks 0 and 1 and data lands in blocks 2 and 3. Two 3-bit configuration counts set the memory layout. One gives how many 32K blocks are fitted. The other gives how many of the lowest blocks hold program code and are therefore write-protected. An access to a block that is not fitted is handed off by raising an external-bus flag, and no enable fires. A power-fail input, like reset, forces every strobe inactive.

Top module: `nvram_ce_decoder`

## Requirements
- R1: When `big_dev`=0 and the access is not a peripheral access, a fetch (`acc_kind`=01), read (10) or write (11) drives low only `ce_n[b]`. Here b is bits 16:15 of the physical address {kind is read or write, `lgc_addr`[15:0]}.
- R2: When `big_dev`=1, an access that is not a peripheral access drives `ce_n[0]` low, `ce_n[1]` to physical bit 16 and `ce_n[2]` to physical bit 15. `ce_n[3]` stays high.
- R3: When `per_mode`=1, a read or write drives low only `pe_n[lgc_addr[15:14]]` and leaves every `ce_n` high.
- R4: When `per_mode`=1, a fetch still decodes onto `ce_n` as in R1 or R2, and every `pe_n` stays high.
- R5: A chip-enable write to a block b with b < `prog_blocks` keeps `wr_n` high while its enable still goes low. Peripheral writes are never protected.
- R6: A write that is not protected drives `wr_n` low. Reads and fetches never do.
- R7: While `rst_n`=0 or `pwr_fail`=1, the next outputs are idle: every enable high, `wr_n` high, `ba`=0 and `ext_bus`=0.
- R8: When `big_dev`=0, an access that is not a peripheral access to a block b with b >= `mem_blocks` sets `ext_bus`=1 and leaves every enable and `wr_n` high. When `big_dev`=1, `mem_blocks` has no effect.
- R9: During a decoded access, `ba` equals physical bits 14:0. Otherwise `ba` is 0.
- R10: Every output reflects the inputs sampled at the previous rising clock edge. At most one strobe acting as an enable is low at a time: all `ce_n`/`pe_n` when `big_dev`=0, or `ce_n[0]`, `ce_n[3]` and `pe_n` when `big_dev`=1.
- R11: With `acc_kind`=00 (idle), every output is idle as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_fail | input | 1 | Power-fail hold, forces idle outputs |
| acc_kind | input | 2 | 00 idle, 01 fetch, 10 read, 11 write |
| lgc_addr | input | 16 | Logical address |
| big_dev | input | 1 | 1: single 128K device, 0: four 32K devices |
| per_mode | input | 1 | 1: data accesses go to peripheral windows |
| mem_blocks | input | 3 | Count of fitted 32K blocks (32K mode) |
| prog_blocks | input | 3 | Count of lowest blocks that are write-protected program space |
| ce_n | output | 4 | Chip enables, active low (in 128K mode [1],[2] carry address bits) |
| pe_n | output | 4 | Peripheral enables, active low, 16K windows |
| ba | output | 15 | Byte address |
| wr_n | output | 1 | Write strobe, active low |
| ext_bus | output | 1 | Access falls outside fitted memory |

## Verification
Every result of this block passes through exactly one register. Stimulus applied on a falling edge therefore appears after the next rising edge. The bench drives each access on a falling edge and samples all outputs on the following falling edge, one full cycle later. Power-fail and reset take effect with the same single-cycle lag, so their checks use the same sampling point. The bench never waits extra cycles that would hide a wrong latency.

// File: rtl/nvd_pkg.sv
`timescale 1ns/1ps
package nvd_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_READ  = 2'b10,
    ACC_WRITE = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/nvd_map.sv
`timescale 1ns/1ps
module nvd_map import nvd_pkg::*; #(
  parameter int LA_W   = 16,
  parameter int NUM_EN = 4
) (
  input  logic [LA_W-1:0]          addr,
  input  acc_kind_e                kind,
  input  logic                     big_dev,
  input  logic                     per_mode,
  input  logic [$clog2(NUM_EN):0]  mem_blocks,
  input  logic [$clog2(NUM_EN):0]  prog_blocks,
  output logic [LA_W:0]            phys,
  output logic [$clog2(NUM_EN)-1:0] blk_idx,
  output logic                     active,
  output logic                     per_hit,
  output logic                     in_range,
  output logic                     wr_prot
);
  localparam int PA_W  = LA_W + 1;
  localparam int BLK_W = $clog2(NUM_EN);

  // data space sits above program space in the physical map
  function automatic logic [PA_W-1:0] to_phys(input logic [LA_W-1:0] a,
                                              input acc_kind_e k);
    return {(k == ACC_READ) || (k == ACC_WRITE), a};
  endfunction

  function automatic logic [BLK_W-1:0] block_of(input logic [PA_W-1:0] p);
    return p[PA_W-1 -: BLK_W];
  endfunction

  logic is_data;

  always_comb begin
    is_data  = (kind == ACC_READ) || (kind == ACC_WRITE);
    phys     = to_phys(addr, kind);
    blk_idx  = block_of(phys);
    active   = (kind != ACC_IDLE);
    per_hit  = per_mode && is_data;
    in_range = big_dev || per_hit || ({1'b0, blk_idx} < mem_blocks);
    wr_prot  = !per_hit && ({1'b0, blk_idx} < prog_blocks);
  end
endmodule

// File: rtl/nvd_enable.sv
`timescale 1ns/1ps
module nvd_enable #(
  parameter int LA_W   = 16,
  parameter int BA_W   = 15,
  parameter int NUM_EN = 4,
  parameter int NUM_PE = 4
) (
  input  logic                      active,
  input  logic                      in_range,
  input  logic                      per_hit,
  input  logic                      big_dev,
  input  logic                      wr_req,
  input  logic                      wr_prot,
  input  logic [LA_W:0]             phys,
  input  logic [$clog2(NUM_EN)-1:0] blk_idx,
  output logic [NUM_EN-1:0]         ce_n_d,
  output logic [NUM_PE-1:0]         pe_n_d,
  output logic [BA_W-1:0]           ba_d,
  output logic                      wr_n_d,
  output logic                      ext_d
);
  localparam int PA_W   = LA_W + 1;
  localparam int BLK_W  = $clog2(NUM_EN);
  localparam int PSEL_W = $clog2(NUM_PE);

  logic              go;
  logic              ce_go;
  logic [PSEL_W-1:0] psel;

  always_comb begin
    go    = active && in_range;
    ce_go = go && !per_hit;
    // peripheral window taken from the top logical address bits
    psel  = phys[LA_W-1 -: PSEL_W];
  end

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    assign pe_n_d[i] = !(go && per_hit && (psel == PSEL_W'(i)));
  end

  for (genvar i = 0; i < NUM_EN; i++) begin : g_ce
    logic sel32;
    logic pin128;
    assign sel32 = ce_go && (blk_idx == BLK_W'(i));
    if (i == 0) begin : g_first
      assign pin128 = !ce_go;
    end else if (i <= BLK_W) begin : g_addr_pin
      // reused pin carries a high physical address bit
      assign pin128 = ce_go ? phys[PA_W-i] : 1'b1;
    end else begin : g_unused
      assign pin128 = 1'b1;
    end
    assign ce_n_d[i] = big_dev ? pin128 : !sel32;
  end

  assign ba_d   = go ? phys[BA_W-1:0] : '0;
  assign wr_n_d = !(go && wr_req && !wr_prot);
  assign ext_d  = active && !in_range;
endmodule

// File: rtl/nvd_outreg.sv
`timescale 1ns/1ps
module nvd_outreg #(
  parameter int BA_W   = 15,
  parameter int NUM_EN = 4,
  parameter int NUM_PE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [NUM_EN-1:0] ce_n_d,
  input  logic [NUM_PE-1:0] pe_n_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic              wr_n_d,
  input  logic              ext_d,
  output logic [NUM_EN-1:0] ce_n_q,
  output logic [NUM_PE-1:0] pe_n_q,
  output logic [BA_W-1:0]   ba_q,
  output logic              wr_n_q,
  output logic              ext_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      ce_n_q <= '1;
      pe_n_q <= '1;
      ba_q   <= '0;
      wr_n_q <= 1'b1;
      ext_q  <= 1'b0;
    end else begin
      ce_n_q <= ce_n_d;
      pe_n_q <= pe_n_d;
      ba_q   <= ba_d;
      wr_n_q <= wr_n_d;
      ext_q  <= ext_d;
    end
  end
endmodule

// File: rtl/nvram_ce_decoder.sv
`timescale 1ns/1ps
module nvram_ce_decoder import nvd_pkg::*; #(
  parameter int LA_W   = 16,
  parameter int BA_W   = 15,
  parameter int NUM_EN = 4,
  parameter int NUM_PE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwr_fail,
  input  logic [1:0]               acc_kind,
  input  logic [LA_W-1:0]          lgc_addr,
  input  logic                     big_dev,
  input  logic                     per_mode,
  input  logic [$clog2(NUM_EN):0]  mem_blocks,
  input  logic [$clog2(NUM_EN):0]  prog_blocks,
  output logic [NUM_EN-1:0]        ce_n,
  output logic [NUM_PE-1:0]        pe_n,
  output logic [BA_W-1:0]          ba,
  output logic                     wr_n,
  output logic                     ext_bus
);
  localparam int BLK_W = $clog2(NUM_EN);

  acc_kind_e         kind;
  logic [LA_W:0]     phys;
  logic [BLK_W-1:0]  blk_idx;
  logic              active, per_hit, in_range, wr_prot;
  logic [NUM_EN-1:0] ce_n_d;
  logic [NUM_PE-1:0] pe_n_d;
  logic [BA_W-1:0]   ba_d;
  logic              wr_n_d, ext_d;

  assign kind = acc_kind_e'(acc_kind);

  nvd_map #(.LA_W(LA_W), .NUM_EN(NUM_EN)) u_map (
    .addr(lgc_addr), .kind(kind), .big_dev(big_dev), .per_mode(per_mode),
    .mem_blocks(mem_blocks), .prog_blocks(prog_blocks),
    .phys(phys), .blk_idx(blk_idx), .active(active), .per_hit(per_hit),
    .in_range(in_range), .wr_prot(wr_prot)
  );

  nvd_enable #(.LA_W(LA_W), .BA_W(BA_W), .NUM_EN(NUM_EN), .NUM_PE(NUM_PE)) u_en (
    .active(active), .in_range(in_range), .per_hit(per_hit), .big_dev(big_dev),
    .wr_req(kind == ACC_WRITE), .wr_prot(wr_prot), .phys(phys), .blk_idx(blk_idx),
    .ce_n_d(ce_n_d), .pe_n_d(pe_n_d), .ba_d(ba_d), .wr_n_d(wr_n_d), .ext_d(ext_d)
  );

  nvd_outreg #(.BA_W(BA_W), .NUM_EN(NUM_EN), .NUM_PE(NUM_PE)) u_reg (
    .clk(clk), .rst_n(rst_n), .hold(pwr_fail),
    .ce_n_d(ce_n_d), .pe_n_d(pe_n_d), .ba_d(ba_d), .wr_n_d(wr_n_d), .ext_d(ext_d),
    .ce_n_q(ce_n), .pe_n_q(pe_n), .ba_q(ba), .wr_n_q(wr_n), .ext_q(ext_bus)
  );
endmodule

// File: rtl/nvd_chk.sv
`timescale 1ns/1ps
module nvd_chk #(
  parameter int BA_W   = 15,
  parameter int NUM_EN = 4,
  parameter int NUM_PE = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pwr_fail,
  input logic [1:0]                acc_kind,
  input logic                      big_dev,
  input logic                      per_mode,
  input logic [$clog2(NUM_EN):0]   prog_blocks,
  input logic [$clog2(NUM_EN)-1:0] blk_idx,
  input logic [NUM_EN-1:0]         ce_n,
  input logic [NUM_PE-1:0]         pe_n,
  input logic [BA_W-1:0]           ba,
  input logic                      wr_n,
  input logic                      ext_bus
);
  // R7
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_fail) |-> (&ce_n && &pe_n && wr_n && !ext_bus && ba == '0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_kind) == 2'b00) |-> (&ce_n && &pe_n && wr_n && !ext_bus));

  // R8
  ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bus |-> (&ce_n && &pe_n && wr_n));

  // R5
  wr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ($past(acc_kind) == 2'b11 &&
               ($past(per_mode) || $past({1'b0, blk_idx}) >= $past(prog_blocks))));

  // R3
  pe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&pe_n) |-> ($past(per_mode) && $past(acc_kind[1])));

  // R2
  top_ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(big_dev) |-> ce_n[NUM_EN-1]);

  // R10
  one_en32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(big_dev) |-> $onehot0({~pe_n, ~ce_n}));

  // R10
  one_en128_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(big_dev) |-> $onehot0({~pe_n, ~ce_n[0], ~ce_n[NUM_EN-1]}));
endmodule

bind nvram_ce_decoder nvd_chk #(.BA_W(BA_W), .NUM_EN(NUM_EN), .NUM_PE(NUM_PE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .acc_kind(acc_kind),
  .big_dev(big_dev), .per_mode(per_mode), .prog_blocks(prog_blocks),
  .blk_idx(blk_idx), .ce_n(ce_n), .pe_n(pe_n), .ba(ba), .wr_n(wr_n),
  .ext_bus(ext_bus)
);

// File: tb/sim_nvram_ce_decoder.sv
`timescale 1ns/1ps
module sim_nvram_ce_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_fail = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [15:0] lgc_addr = '0;
  logic        big_dev = 1'b0;
  logic        per_mode = 1'b0;
  logic [2:0]  mem_blocks = 3'd4;
  logic [2:0]  prog_blocks = 3'd0;
  logic [3:0]  ce_n;
  logic [3:0]  pe_n;
  logic [14:0] ba;
  logic        wr_n;
  logic        ext_bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  x_ce, x_pe;
  logic [14:0] x_ba;
  logic        x_wr, x_ext;

  always #10 clk = ~clk;

  nvram_ce_decoder u0 (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .acc_kind(acc_kind),
    .lgc_addr(lgc_addr), .big_dev(big_dev), .per_mode(per_mode),
    .mem_blocks(mem_blocks), .prog_blocks(prog_blocks),
    .ce_n(ce_n), .pe_n(pe_n), .ba(ba), .wr_n(wr_n), .ext_bus(ext_bus)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected outputs restated from the requirements
  task automatic predict(input logic [1:0] k, input logic [15:0] a);
    logic        is_data;
    logic [16:0] p;
    int          b;
    is_data = (k == 2'b10) || (k == 2'b11);
    p = {is_data, a};
    b = int'(p[16:15]);
    x_ce = 4'hF; x_pe = 4'hF; x_ba = '0; x_wr = 1'b1; x_ext = 1'b0;
    if (!rst_n || pwr_fail || k == 2'b00) return;
    if (per_mode && is_data) begin
      x_pe[a[15:14]] = 1'b0;
      x_ba = a[14:0];
      x_wr = !(k == 2'b11);
    end else if (!big_dev && b >= int'(mem_blocks)) begin
      x_ext = 1'b1;
    end else begin
      x_ba = p[14:0];
      if (big_dev) begin
        x_ce[0] = 1'b0; x_ce[1] = p[16]; x_ce[2] = p[15];
      end else begin
        x_ce[b] = 1'b0;
      end
      x_wr = !(k == 2'b11 && b >= int'(prog_blocks));
    end
  endtask

  task automatic access(input string tag, input logic [1:0] k, input logic [15:0] a);
    @(negedge clk);
    acc_kind = k;
    lgc_addr = a;
    predict(k, a);
    @(negedge clk);
    chk(tag, "ce_n", int'(ce_n), int'(x_ce));
    chk(tag, "pe_n", int'(pe_n), int'(x_pe));
    chk(tag, "ba", int'(ba), int'(x_ba));
    chk(tag, "wr_n", int'(wr_n), int'(x_wr));
    chk(tag, "ext_bus", int'(ext_bus), int'(x_ext));
  endtask

  task automatic cfg(input logic b, input logic p, input logic [2:0] m, input logic [2:0] g);
    @(negedge clk);
    acc_kind = 2'b00;
    big_dev = b; per_mode = p; mem_blocks = m; prog_blocks = g;
  endtask

  // R7: reset state
  task automatic t_reset;
    @(negedge clk);
    chk("R7", "ce_n", int'(ce_n), 15);
    chk("R7", "pe_n", int'(pe_n), 15);
    chk("R7", "wr_n", int'(wr_n), 1);
    chk("R7", "ext_bus", int'(ext_bus), 0);
    rst_n = 1'b1;
  endtask

  // R1, R9, R6
  task automatic t_small_dev;
    cfg(1'b0, 1'b0, 3'd4, 3'd0);
    access("R1", 2'b01, 16'h0123);
    access("R1", 2'b01, 16'h8ABC);
    access("R9", 2'b10, 16'h7FFF);
    access("R6", 2'b11, 16'hC001);
  endtask

  // R2
  task automatic t_big_dev;
    cfg(1'b1, 1'b0, 3'd1, 3'd0);
    access("R2", 2'b01, 16'h8000);
    access("R2", 2'b10, 16'h0042);
    access("R2", 2'b11, 16'hF0F0);
    chk("R2", "ce_n3", int'(ce_n[3]), 1);
  endtask

  // R3, R4
  task automatic t_periph;
    cfg(1'b0, 1'b1, 3'd4, 3'd0);
    for (int w = 0; w < 4; w++) access("R3", 2'b10, 16'(w * 16'h4000 + 16'h0155));
    access("R3", 2'b11, 16'hC7A0);
    access("R4", 2'b01, 16'hC7A0);
    cfg(1'b1, 1'b1, 3'd4, 3'd0);
    access("R4", 2'b01, 16'h4321);
    access("R3", 2'b10, 16'h4321);
  endtask

  // R5, R6
  task automatic t_protect;
    cfg(1'b0, 1'b0, 3'd4, 3'd3);
    access("R5", 2'b11, 16'h0123);
    chk("R5", "ce_n_blk2", int'(ce_n[2]), 0);
    access("R6", 2'b11, 16'h8123);
    access("R6", 2'b10, 16'h8123);
    cfg(1'b0, 1'b1, 3'd4, 3'd4);
    access("R5", 2'b11, 16'h2222);
    cfg(1'b1, 1'b0, 3'd4, 3'd4);
    access("R5", 2'b11, 16'h9999);
  endtask

  // R8
  task automatic t_range;
    cfg(1'b0, 1'b0, 3'd3, 3'd0);
    access("R8", 2'b10, 16'h9000);
    access("R8", 2'b11, 16'hFFFF);
    access("R8", 2'b10, 16'h1000);
    cfg(1'b0, 1'b0, 3'd1, 3'd0);
    access("R8", 2'b01, 16'h8000);
    cfg(1'b1, 1'b0, 3'd0, 3'd0);
    access("R8", 2'b11, 16'hFFFF);
  endtask

  // R7, R11
  task automatic t_hold;
    cfg(1'b0, 1'b0, 3'd4, 3'd0);
    @(negedge clk); pwr_fail = 1'b1;
    access("R7", 2'b11, 16'h8001);
    @(negedge clk); pwr_fail = 1'b0;
    access("R7", 2'b11, 16'h8001);
    access("R11", 2'b00, 16'h8001);
    @(negedge clk); rst_n = 1'b0;
    access("R7", 2'b10, 16'h0001);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // R10: latency and single active enable over a sweep
  task automatic t_sweep;
    cfg(1'b0, 1'b0, 3'd4, 3'd0);
    @(negedge clk); acc_kind = 2'b10; lgc_addr = 16'h0000;
    @(posedge clk);
    #2;
    chk("R10", "ce_n_latency", int'(ce_n[2]), 0);
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 16; s++) begin
        logic [3:0] lowc;
        cfg(m[0], m[1], 3'd4, 3'd0);
        access("R10", 2'(s % 4), 16'(s * 16'h1111));
        lowc = 4'd0;
        for (int i = 0; i < 4; i++) if (!pe_n[i]) lowc++;
        if (!ce_n[0]) lowc++;
        if (!ce_n[3]) lowc++;
        if (!m[0]) begin
          if (!ce_n[1]) lowc++;
          if (!ce_n[2]) lowc++;
        end
        chk("R10", "enables_low", int'(lowc > 1), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_small_dev();
    t_big_dev();
    t_periph();
    t_protect();
    t_range();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule